// File: doc/BRIEF.md
# Level-Sensitive Interrupt Router

This block gathers up to 32 level-sensitive interrupt request lines and presents them to a processor on two interrupt outputs. Software reaches it through a simple single-cycle register port. Each source has an enable bit. Software turns enables on through a write-one-to-set register and off through a separate write-one-to-clear register, so no read-modify-write is ever needed. A routing register steers each source to processor output 0 or output 1. The top bit of the enable vector does not act as a per-source enable. It is a master gate: neither output can assert while it is clear.

Request lines are sampled into a register. Software can read them unmasked through a raw register, or through two per-output status registers that apply both the enable and the routing. Each processor output is a flop that holds the OR of its status bits, gated by the master bit. The source in the top position shares its enable bit with that gate.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset, every enable bit and every routing bit is 0, both `cpu_irq` bits are 0, and `bus_rdata` is 0.
- R2: A write to offset 0x34 sets each enable bit whose write-data bit is 1 and leaves enable bits under 0 data bits unchanged.
- R3: A write to offset 0x38 clears each enable bit whose write-data bit is 1. Writing all ones clears every enable, including the master gate.
- R4: A read of offset 0x34 or of offset 0x38 returns the current enable vector.
- R5: Offset 0x20 is a read/write routing register. A routing bit of 0 sends that source to output 0, and a 1 sends it to output 1. Writing 0 sends every source to output 0.
- R6: A read of offset 0x00 returns sampled level AND enable AND NOT routing. A read of offset 0x04 returns sampled level AND enable AND routing. The two never share a set bit.
- R7: A read of offset 0x30 returns the sampled request levels, whatever the enable and routing settings.
- R8: Enable bit 31 (the top source bit) is the master gate. While it is 0, both `cpu_irq` bits stay 0, even when the status registers are nonzero.
- R9: `cpu_irq[k]` is a register equal to the OR of status register k, gated by the master bit. A change on `irq_src` reaches `cpu_irq` two clock edges later (one sample stage and one output stage). A dropped line deasserts its output the same way.
- R10: A read of an unmapped offset returns 0. Writes to the status offsets, the raw offset and unmapped offsets change no state.
- R11: `bus_rdata` is registered. It carries the read result in the cycle after the read request and is 0 in the cycle after any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | NUM_SRC | Level-sensitive request lines |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, one cycle after the request |
| cpu_irq | output | 2 | Interrupt lines to the processor |

## Verification
The bench builds the block with its defaults: 32 sources, a 32-bit data bus, an 8-bit offset and the input sample stage enabled. With the full 32-source width, the master gate sits at bit 31. The bench can therefore show the gate's effect on both outputs and the all-ones clear that takes the gate down with the sources. With the sample stage present, the two-edge path from request line to output is exercised on both rising and falling lines.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
   // register offsets; software depends on these values
   localparam logic [7:0] OFS_STAT0 = 8'h00;
   localparam logic [7:0] OFS_STAT1 = 8'h04;
   localparam logic [7:0] OFS_ROUTE = 8'h20;
   localparam logic [7:0] OFS_RAW   = 8'h30;
   localparam logic [7:0] OFS_ENSET = 8'h34;
   localparam logic [7:0] OFS_ENCLR = 8'h38;

   typedef enum logic [2:0] {
      RS_NONE, RS_STAT0, RS_STAT1, RS_ROUTE, RS_RAW, RS_ENSET, RS_ENCLR
   } reg_sel_e;
endpackage

// File: rtl/lvl_irq_regs.sv
module lvl_irq_regs #(
   parameter int NUM_SRC = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_we,
   input  logic               clr_we,
   input  logic               route_we,
   input  logic [NUM_SRC-1:0] wbits,
   output logic [NUM_SRC-1:0] en_q,
   output logic [NUM_SRC-1:0] route_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q    <= '0;
         route_q <= '0;
      end else begin
         if (set_we)   en_q    <= en_q | wbits;
         if (clr_we)   en_q    <= en_q & ~wbits;
         if (route_we) route_q <= wbits;
      end
   end

   AST_SET_HITS: assert property (@(posedge clk) disable iff (!rst_n)
      set_we |=> ((en_q & $past(wbits)) == $past(wbits)));        // R2
   AST_SET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      set_we |=> ((en_q & ~$past(wbits)) == ($past(en_q) & ~$past(wbits)))); // R2
   AST_CLR_HITS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> ((en_q & $past(wbits)) == '0));                   // R3
   AST_EN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_we || clr_we) |=> $stable(en_q));                      // R10
endmodule

// File: rtl/lvl_irq_route.sv
module lvl_irq_route #(
   parameter int NUM_SRC = 32
) (
   input  logic [NUM_SRC-1:0] level,
   input  logic [NUM_SRC-1:0] en,
   input  logic [NUM_SRC-1:0] route,
   output logic [NUM_SRC-1:0] stat0,
   output logic [NUM_SRC-1:0] stat1
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic live;
      assign live     = level[i] & en[i];
      assign stat0[i] = live & ~route[i];
      assign stat1[i] = live &  route[i];
   end
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
   import lvl_irq_pkg::*;
#(
   parameter int NUM_SRC   = 32,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 8,
   parameter bit SAMPLE_IN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_src,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic [1:0]         cpu_irq
);
   localparam int GATE_BIT = NUM_SRC - 1;

   if (NUM_SRC < 2 || NUM_SRC > DATA_W) begin : g_bad_src
      $error("NUM_SRC must lie in 2..DATA_W");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must be at least 8");
   end

   logic [NUM_SRC-1:0] level, en_q, route_q, stat0, stat1;
   reg_sel_e           rsel;
   logic               do_wr, do_rd, gate;

   // sample stage variant
   if (SAMPLE_IN) begin : g_sample
      logic [NUM_SRC-1:0] lvl_q;
      always_ff @(posedge clk) begin
         if (!rst_n) lvl_q <= '0;
         else        lvl_q <= irq_src;
      end
      assign level = lvl_q;
   end else begin : g_direct
      assign level = irq_src;
   end

   always_comb begin
      if      (bus_addr == ADDR_W'(OFS_STAT0)) rsel = RS_STAT0;
      else if (bus_addr == ADDR_W'(OFS_STAT1)) rsel = RS_STAT1;
      else if (bus_addr == ADDR_W'(OFS_ROUTE)) rsel = RS_ROUTE;
      else if (bus_addr == ADDR_W'(OFS_RAW))   rsel = RS_RAW;
      else if (bus_addr == ADDR_W'(OFS_ENSET)) rsel = RS_ENSET;
      else if (bus_addr == ADDR_W'(OFS_ENCLR)) rsel = RS_ENCLR;
      else                                     rsel = RS_NONE;
   end

   assign do_wr = bus_sel &  bus_wr;
   assign do_rd = bus_sel & ~bus_wr;

   lvl_irq_regs #(.NUM_SRC(NUM_SRC)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_we   (do_wr && rsel == RS_ENSET),
      .clr_we   (do_wr && rsel == RS_ENCLR),
      .route_we (do_wr && rsel == RS_ROUTE),
      .wbits    (bus_wdata[NUM_SRC-1:0]),
      .en_q     (en_q),
      .route_q  (route_q)
   );

   lvl_irq_route #(.NUM_SRC(NUM_SRC)) u_route (
      .level (level),
      .en    (en_q),
      .route (route_q),
      .stat0 (stat0),
      .stat1 (stat1)
   );

   assign gate = en_q[GATE_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cpu_irq   <= '0;
         bus_rdata <= '0;
      end else begin
         cpu_irq <= {gate & (|stat1), gate & (|stat0)};
         if (do_rd) begin
            unique case (rsel)
               RS_STAT0:          bus_rdata <= DATA_W'(stat0);
               RS_STAT1:          bus_rdata <= DATA_W'(stat1);
               RS_ROUTE:          bus_rdata <= DATA_W'(route_q);
               RS_RAW:            bus_rdata <= DATA_W'(level);
               RS_ENSET, RS_ENCLR: bus_rdata <= DATA_W'(en_q);
               default:           bus_rdata <= '0;
            endcase
         end else begin
            bus_rdata <= '0;
         end
      end
   end

   AST_GATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (|cpu_irq) |-> $past(gate));                                 // R8
   AST_ROUTE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      (stat0 & stat1) == '0);                                      // R6
   AST_OUT0_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq[0] |-> $past(|stat0));                               // R9
   AST_OUT1_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq[1] |-> $past(|stat1));                               // R9
   AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !do_rd |=> (bus_rdata == '0));                               // R11
endmodule

// File: tb/lvl_irq_ctrl_tb.sv
module lvl_irq_ctrl_tb;
   localparam int NS = 32;
   localparam int DW = 32;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] irq_src = '0;
   logic          bus_sel = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic [1:0]    cpu_irq;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   typedef struct {
      logic [DW-1:0] exp;
      string         tag;
   } exp_t;
   exp_t sb_q[$];
   logic rd_pend = 1'b0;

   always #4ns clk = ~clk;   // 125 MHz

   lvl_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .irq_src(irq_src),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
   );

   // monitor: a read request seen at an edge yields data for the following negedge
   always @(posedge clk) rd_pend <= bus_sel & ~bus_wr;

   always @(negedge clk) begin
      if (rd_pend && sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         n_cmp++;
         if (bus_rdata !== e.exp) begin
            n_bad++;
            $display("FAIL %s read: got %h expected %h", e.tag, bus_rdata, e.exp);
         end
      end else if (!rd_pend && rst_n) begin
         n_cmp++;
         if (bus_rdata !== '0) begin
            n_bad++;
            $display("FAIL R11 idle rdata: got %h expected 0", bus_rdata);
         end
      end
   end

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
      exp_t item;
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      item.exp = e; item.tag = tag;
      sb_q.push_back(item);
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic settle();
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic chk_irq(input logic [1:0] e, input string tag);
      n_cmp++;
      if (cpu_irq !== e) begin
         n_bad++;
         $display("FAIL %s cpu_irq: got %b expected %b", tag, cpu_irq, e);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(8ns * 200000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_irq(2'b00, "R1");
      rd(8'h34, 32'h0, "R1");
      rd(8'h20, 32'h0, "R1");

      wr(8'h34, 32'h0000_00F0);
      rd(8'h34, 32'h0000_00F0, "R2");
      wr(8'h34, 32'h0000_0003);
      rd(8'h34, 32'h0000_00F3, "R2");
      wr(8'h38, 32'h0000_0030);
      rd(8'h38, 32'h0000_00C3, "R3");
      rd(8'h34, 32'h0000_00C3, "R4");

      wr(8'h20, 32'h0000_0082);
      rd(8'h20, 32'h0000_0082, "R5");

      @(negedge clk); irq_src = 32'h0000_01C3;
      settle();
      rd(8'h30, 32'h0000_01C3, "R7");
      rd(8'h00, 32'h0000_0041, "R6");
      rd(8'h04, 32'h0000_0082, "R6");
      chk_irq(2'b00, "R8");

      wr(8'h34, 32'h8000_0000);
      settle();
      chk_irq(2'b11, "R9");
      rd(8'h34, 32'h8000_00C3, "R4");

      @(negedge clk); irq_src = 32'h0000_0002;
      @(negedge clk);
      chk_irq(2'b11, "R9");   // output stage not yet updated
      @(negedge clk);
      chk_irq(2'b10, "R9");
      @(negedge clk); irq_src = '0;
      settle();
      chk_irq(2'b00, "R9");

      wr(8'h30, 32'hFFFF_FFFF);
      wr(8'h00, 32'hFFFF_FFFF);
      wr(8'h10, 32'hFFFF_FFFF);
      rd(8'h30, 32'h0, "R10");
      rd(8'h10, 32'h0, "R10");
      rd(8'h20, 32'h0000_0082, "R10");
      rd(8'h34, 32'h8000_00C3, "R10");

      wr(8'h34, 32'h0000_00FF);
      wr(8'h20, 32'h0);
      @(negedge clk); irq_src = 32'h0000_00FF;
      settle();
      rd(8'h00, 32'h0000_00FF, "R5");
      rd(8'h04, 32'h0, "R5");
      chk_irq(2'b01, "R5");

      wr(8'h38, 32'hFFFF_FFFF);
      rd(8'h38, 32'h0, "R3");
      settle();
      chk_irq(2'b00, "R3");
      rd(8'h30, 32'h0000_00FF, "R7");

      wr(8'h34, 32'h0000_00FF);
      settle();
      chk_irq(2'b00, "R8");
      rd(8'h00, 32'h0000_00FF, "R8");

      settle();
      n_cmp++;
      if (sb_q.size() != 0) begin
         n_bad++;
         $display("FAIL R11 queue: got %0d expected 0", sb_q.size());
      end
      finish_run();
   end
endmodule